// File: doc/BRIEF.md
# SPI Transfer Engine with Status Register

This block shifts characters of 1 to 8 bits over a serial link, either as the master, which steps one bit per external bit tick, or as a slave clocked by an external serial clock and selected by an active-low select pin. Alongside the engine sits an 8-bit status register. It reports a pending interrupt, a receive overrun, a multi-master collision, an early release of the select line in slave mode, whether a transfer is in progress, and the level of the select pin.

Software reads the status register over a simple register port. It clears the four event flags by writing ones to their positions. A level input lets software force the interrupt flag. A second input marks the bit-tick source as running as a plain timer, and while it is high the master engine ignores bit ticks. Setting the enable input to 0 stops the engine and holds the whole status register at its reset value.

Top module: `spi_stat_ctrl`

## Requirements
- R1: After reset, and on every cycle after a cycle in which `spi_en` was 0, `status` reads 8'h01 and no transfer is in progress.
- R2: The status layout is bit 7 interrupt, bit 6 overrun, bit 5 collision, bit 4 slave abort, bits 3:2 always 0, bit 1 transfer in progress, bit 0 select-pin state.
- R3: A register write with bit 7, 6, 5 or 4 set to 1 clears that flag on the next cycle. A 0 in those positions leaves the flag unchanged. Bits 3:0 of a write have no effect.
- R4: When a set event and a write-one clear reach the same flag in the same cycle, the flag reads 1 afterwards.
- R5: While enabled, the interrupt flag sets on the cycle after the last bit of a character is shifted, in both master and slave mode.
- R6: While enabled, `force_irq` high sets the interrupt flag. While `spi_en` is 0, nothing sets it. While `brg_timer` is 1, master bit ticks neither shift nor complete a character.
- R7: `char_bits` selects the character length: code 0 means 8 bits, and codes 1 to 7 mean that many bits. The low `len` bits of the transmit data leave on `sdo` MSB first, one bit per step. After the last step, `rx_data` holds the `len` received bits right-aligned, with the upper bits 0.
- R8: Status bit 1 reads 1 from the cycle after a transfer starts until the cycle after its last bit, abort or collision, and reads 0 otherwise.
- R9: In slave mode, if `ss_n` goes high after at least one bit of a character and before its last bit, the abort flag and the interrupt flag both set and the transfer ends. If `ss_n` goes high before any bit is shifted, neither flag sets.
- R10: The overrun flag sets when a character completes while the previous received character has not been taken with `rx_rd`. A `rx_rd` in the same cycle as the completion counts as taken.
- R11: In master mode with `spi_en` high, `ss_n` low sets the collision flag and stops any master transfer.
- R12: While enabled, status bit 0 equals the value `ss_n` had one cycle earlier (0 means selected).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_en | input | 1 | Enable; 0 stops the engine and holds status at reset |
| is_master | input | 1 | 1 = master, 0 = slave |
| brg_timer | input | 1 | Bit-tick source runs as a timer; inhibits master shifting |
| char_bits | input | 3 | Character length code (0 = 8 bits) |
| tx_load | input | 1 | Load transmit data; in master mode also starts a transfer |
| tx_data | input | 8 | Transmit character |
| bit_tick | input | 1 | Master bit-step pulse |
| sck_in | input | 1 | Slave serial clock; a bit shifts on its rising edge |
| sdi | input | 1 | Serial data in |
| ss_n | input | 1 | Slave select pin, active low |
| force_irq | input | 1 | Software interrupt trigger (level) |
| rx_rd | input | 1 | Received character taken |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Write data; ones clear flags in bits 7:4 |
| sdo | output | 1 | Serial data out |
| rx_data | output | 8 | Last received character |
| status | output | 8 | Status register |

## Verification
The hardest state to reach from the ports is a slave character cut short. The select line must rise strictly between the first and the last bit, and this has to be told apart from a release before any bit and from a release just after the last bit, when the engine would otherwise rearm. Directed slave sequences drive the serial clock by hand and release the select line at each of these three points. A seeded random stream of master and slave characters, of random length and content, sometimes skips `rx_rd` so that overruns arise in the middle of ordinary traffic.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int CHAR_W = 8;
  localparam int CNT_W  = $clog2(CHAR_W + 1);
  localparam int SEL_W  = $clog2(CHAR_W);

  // status bit positions (software decodes these)
  localparam int B_IRQ  = 7;
  localparam int B_OVR  = 6;
  localparam int B_COL  = 5;
  localparam int B_ABT  = 4;
  localparam int B_TXST = 1;
  localparam int B_SLAS = 0;
  localparam int FLAG_N = 4;

  typedef logic [CHAR_W-1:0] char_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // length code 0 selects the full character width
  function automatic cnt_t len_of(input logic [SEL_W-1:0] code);
    if (code == '0) return cnt_t'(CHAR_W);
    return cnt_t'(code);
  endfunction

  function automatic char_t char_mask(input cnt_t len);
    logic [CHAR_W:0] one_h;
    one_h = ((CHAR_W+1)'(1) << len) - (CHAR_W+1)'(1);
    return one_h[CHAR_W-1:0];
  endfunction

  // left-align the low len bits so the MSB of the character leaves first
  function automatic char_t align_tx(input char_t data, input cnt_t len);
    return data << (cnt_t'(CHAR_W) - len);
  endfunction

  // write-one-to-clear flag with set priority
  function automatic logic w1c_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction
endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             master,
  input  logic             brg_timer,
  input  logic [SEL_W-1:0] nbits,
  input  logic             tx_load,
  input  char_t            tx_data,
  input  logic             bit_tick,
  input  logic             sck_in,
  input  logic             sdi,
  input  logic             ss_n,
  output logic             busy,
  output logic             sdo,
  output char_t            rx_char,
  output logic             done_ev,
  output logic             abort_ev,
  output logic             fault_ev
);
  cnt_t  cnt;
  char_t shreg, tx_hold, shift_val;
  logic  sck_q, shifted;
  cnt_t  len;
  logic  m_step, s_step, step_ev, start_m, start_s, drop_s;

  assign len       = len_of(nbits);
  assign shift_val = {shreg[CHAR_W-2:0], sdi};
  assign sdo       = shreg[CHAR_W-1];

  // named events
  assign fault_ev = en & master & ~ss_n;
  assign abort_ev = en & ~master & busy & ss_n & shifted;
  assign drop_s   = en & ~master & busy & ss_n;
  assign m_step   = en & master & busy & bit_tick & ~brg_timer & ~fault_ev;
  assign s_step   = en & ~master & busy & ~ss_n & sck_in & ~sck_q;
  assign step_ev  = m_step | s_step;
  assign done_ev  = step_ev & (cnt == cnt_t'(1));
  assign start_m  = en & master & ~busy & tx_load & ~fault_ev;
  assign start_s  = en & ~master & ~busy & ~ss_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      tx_hold <= '0;
      rx_char <= '0;
      sck_q   <= 1'b0;
      shifted <= 1'b0;
    end else begin
      sck_q <= sck_in;
      if (tx_load) tx_hold <= tx_data;
      if (!en) begin
        busy    <= 1'b0;
        shifted <= 1'b0;
      end else if (start_m) begin
        busy    <= 1'b1;
        cnt     <= len;
        shreg   <= align_tx(tx_data, len);
        shifted <= 1'b0;
      end else if (start_s) begin
        busy    <= 1'b1;
        cnt     <= len;
        shreg   <= align_tx(tx_hold, len);
        shifted <= 1'b0;
      end else if (fault_ev || drop_s) begin
        busy    <= 1'b0;
        shifted <= 1'b0;
      end else if (step_ev) begin
        shreg   <= shift_val;
        cnt     <= cnt - cnt_t'(1);
        shifted <= 1'b1;
        if (cnt == cnt_t'(1)) begin
          busy    <= 1'b0;
          rx_char <= shift_val & char_mask(len);
        end
      end
    end
  end

  a_r8_done_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> !busy);
  a_r7_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt >= cnt_t'(1) && cnt <= cnt_t'(CHAR_W)));
  a_r7_start_loads_len: assert property (@(posedge clk) disable iff (!rst_n)
    start_m |=> (busy && cnt == $past(len)));
  a_r11_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
    fault_ev |=> !busy);
  a_r9_abort_ends: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> !busy);
  a_r6_timer_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (en && master && busy && brg_timer && !fault_ev) |=> $stable(cnt));
endmodule

// File: rtl/spi_status_reg.sv
module spi_status_reg
  import spi_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ss_n,
  input  logic              busy,
  input  logic              done_ev,
  input  logic              abort_ev,
  input  logic              fault_ev,
  input  logic              force_irq,
  input  logic              rx_rd,
  input  logic              wr_en,
  input  logic [FLAG_N-1:0] wr_hi,
  output char_t             stat
);
  logic irq, ovr, col, abt, slas, rx_full;
  logic irq_set, ovr_set, col_set, abt_set;
  logic [FLAG_N-1:0] clr;

  assign irq_set = en & (done_ev | abort_ev | force_irq);
  assign ovr_set = en & done_ev & rx_full & ~rx_rd;
  assign col_set = en & fault_ev;
  assign abt_set = en & abort_ev;
  assign clr     = wr_en ? wr_hi : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {irq, ovr, col, abt} <= '0;
      slas    <= 1'b1;
      rx_full <= 1'b0;
    end else if (!en) begin
      {irq, ovr, col, abt} <= '0;
      slas    <= 1'b1;
      rx_full <= 1'b0;
    end else begin
      irq     <= w1c_next(irq, irq_set, clr[3]);
      ovr     <= w1c_next(ovr, ovr_set, clr[2]);
      col     <= w1c_next(col, col_set, clr[1]);
      abt     <= w1c_next(abt, abt_set, clr[0]);
      slas    <= ss_n;
      rx_full <= done_ev | (rx_full & ~rx_rd);
    end
  end

  always_comb begin
    stat         = '0;
    stat[B_IRQ]  = irq;
    stat[B_OVR]  = ovr;
    stat[B_COL]  = col;
    stat[B_ABT]  = abt;
    stat[B_TXST] = busy;
    stat[B_SLAS] = slas;
  end

  a_r1_off_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (stat == char_t'(8'h01)));
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set && clr[3]) |=> stat[B_IRQ]);
  a_r3_clear_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr[2] && !ovr_set) |=> !stat[B_OVR]);
  a_r5_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (en && done_ev) |=> stat[B_IRQ]);
  a_r9_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (en && abort_ev) |=> (stat[B_ABT] && stat[B_IRQ]));
  a_r10_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> stat[B_OVR]);
  a_r11_collision: assert property (@(posedge clk) disable iff (!rst_n)
    col_set |=> stat[B_COL]);
  a_r12_select_state: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (stat[B_SLAS] == $past(ss_n)));
endmodule

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
  import spi_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_en,
  input  logic             is_master,
  input  logic             brg_timer,
  input  logic [SEL_W-1:0] char_bits,
  input  logic             tx_load,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic             bit_tick,
  input  logic             sck_in,
  input  logic             sdi,
  input  logic             ss_n,
  input  logic             force_irq,
  input  logic             rx_rd,
  input  logic             reg_wr,
  input  logic [CHAR_W-1:0] reg_wdata,
  output logic             sdo,
  output logic [CHAR_W-1:0] rx_data,
  output logic [CHAR_W-1:0] status
);
  logic busy, done_ev, abort_ev, fault_ev;
  logic [CHAR_W-FLAG_N-1:0] wr_unused_lo;

  assign wr_unused_lo = reg_wdata[CHAR_W-FLAG_N-1:0];

  spi_shift_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (spi_en),
    .master   (is_master),
    .brg_timer(brg_timer),
    .nbits    (char_bits),
    .tx_load  (tx_load),
    .tx_data  (tx_data),
    .bit_tick (bit_tick),
    .sck_in   (sck_in),
    .sdi      (sdi),
    .ss_n     (ss_n),
    .busy     (busy),
    .sdo      (sdo),
    .rx_char  (rx_data),
    .done_ev  (done_ev),
    .abort_ev (abort_ev),
    .fault_ev (fault_ev)
  );

  spi_status_reg u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (spi_en),
    .ss_n     (ss_n),
    .busy     (busy),
    .done_ev  (done_ev),
    .abort_ev (abort_ev),
    .fault_ev (fault_ev),
    .force_irq(force_irq),
    .rx_rd    (rx_rd),
    .wr_en    (reg_wr),
    .wr_hi    (reg_wdata[CHAR_W-1:CHAR_W-FLAG_N]),
    .stat     (status)
  );

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[3:2] == 2'b00);
endmodule

// File: tb/tb_spi_stat_ctrl.sv
module tb_spi_stat_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_en = 0, is_master = 1, brg_timer = 0;
  logic [2:0] char_bits = 0;
  logic tx_load = 0, bit_tick = 0, sck_in = 0, sdi = 0, ss_n = 1;
  logic [7:0] tx_data = 0, reg_wdata = 0;
  logic force_irq = 0, rx_rd = 0, reg_wr = 0;
  logic sdo;
  logic [7:0] rx_data, status;
  int total = 0, bad = 0, cyc = 0;
  bit exp_full = 0;

  always #2 clk = ~clk;

  spi_stat_ctrl dut (
    .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .is_master(is_master),
    .brg_timer(brg_timer), .char_bits(char_bits), .tx_load(tx_load),
    .tx_data(tx_data), .bit_tick(bit_tick), .sck_in(sck_in), .sdi(sdi),
    .ss_n(ss_n), .force_irq(force_irq), .rx_rd(rx_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .sdo(sdo), .rx_data(rx_data), .status(status)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL R8 watchdog expired actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int blen(input logic [2:0] code);
    return (code == 3'd0) ? 8 : int'(code);
  endfunction
  function automatic logic [7:0] bmask(input int n);
    logic [7:0] m = 8'h00;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // clear the four flags; optionally take the received character
  task automatic clear_all(input bit take);
    reg_wdata = 8'hF0; reg_wr = 1; rx_rd = take;
    step();
    reg_wr = 0; rx_rd = 0; reg_wdata = 0;
    if (take) exp_full = 0;
  endtask

  task automatic m_xfer(input logic [2:0] code, input logic [7:0] tx, input logic [7:0] rxv);
    int n = blen(code);
    bit was_full = exp_full;
    char_bits = code; tx_data = tx; tx_load = 1;
    step();
    tx_load = 0;
    chk("R8", status[1], 1, "master busy after start");
    for (int i = n - 1; i >= 0; i--) begin
      chk("R7", sdo, tx[i], "master sdo bit");
      sdi = rxv[i]; bit_tick = 1;
      step();
      bit_tick = 0;
    end
    chk("R8", status[1], 0, "master idle after last bit");
    chk("R5", status[7], 1, "irq after master char");
    chk("R7", rx_data, rxv & bmask(n), "master rx_data");
    chk("R10", status[6], was_full, "overrun vs unread char");
    exp_full = 1;
  endtask

  // cut < n stops after cut bits by releasing select
  task automatic s_xfer(input logic [2:0] code, input logic [7:0] tx, input logic [7:0] rxv, input int cut);
    int n = blen(code);
    bit was_full = exp_full;
    char_bits = code; tx_data = tx; tx_load = 1;
    step();
    tx_load = 0; ss_n = 0;
    step();
    chk("R8", status[1], 1, "slave busy after select");
    chk("R12", status[0], 0, "select state low");
    for (int k = 0; k < n; k++) begin
      if (k == cut) break;
      chk("R7", sdo, tx[n-1-k], "slave sdo bit");
      sdi = rxv[n-1-k]; sck_in = 1;
      step();
      if (k == n - 1) begin
        ss_n = 1;
        chk("R8", status[1], 0, "slave idle after last bit");
        chk("R5", status[7], 1, "irq after slave char");
        chk("R7", rx_data, rxv & bmask(n), "slave rx_data");
        chk("R10", status[6], was_full, "slave overrun");
        exp_full = 1;
      end
      sck_in = 0;
      step();
    end
    if (cut < n) begin
      ss_n = 1;
      step();
      chk("R9", status[4], (cut > 0) ? 1 : 0, "abort flag on early release");
      chk("R9", status[7], (cut > 0) ? 1 : 0, "irq on early release");
      chk("R8", status[1], 0, "slave idle after release");
    end
    chk("R9", status[4], (cut > 0 && cut < n) ? 1 : 0, "abort flag final");
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) step();
    chk("R1", status, 8'h01, "reset value");
    rst_n = 1;
    step();
    chk("R1", status, 8'h01, "after reset release");

    // disabled: nothing sets
    force_irq = 1; tx_load = 1; bit_tick = 1; brg_timer = 1;
    step(); step();
    force_irq = 0; tx_load = 0; bit_tick = 0; brg_timer = 0;
    chk("R6", status, 8'h01, "no irq while disabled");

    spi_en = 1; is_master = 1;
    step();
    chk("R2", status, 8'h01, "enabled idle layout");
    force_irq = 1;
    step();
    chk("R6", status, 8'h81, "forced irq");
    reg_wdata = 8'h80; reg_wr = 1;
    step();
    reg_wr = 0;
    chk("R4", status[7], 1, "set beats clear");
    force_irq = 0; reg_wdata = 8'h70; reg_wr = 1;
    step();
    chk("R3", status[7], 1, "zero in bit7 keeps irq");
    reg_wdata = 8'h0F;
    step();
    chk("R3", status, 8'h81, "low write bits ignored");
    reg_wdata = 8'h80;
    step();
    reg_wr = 0;
    chk("R3", status, 8'h01, "w1c clears irq");

    // timer inhibit
    char_bits = 3; tx_data = 8'h05; tx_load = 1;
    step();
    tx_load = 0; brg_timer = 1;
    repeat (5) begin bit_tick = 1; step(); bit_tick = 0; step(); end
    chk("R6", status, 8'h03, "ticks inhibited in timer mode");
    brg_timer = 0;
    repeat (3) begin bit_tick = 1; step(); bit_tick = 0; end
    chk("R5", status, 8'h81, "done after timer released");
    exp_full = 1;
    clear_all(1);

    // length corners
    m_xfer(3'd0, 8'hA5, 8'h3C); clear_all(1);
    m_xfer(3'd1, 8'h01, 8'h01); clear_all(1);
    // overrun
    m_xfer(3'd4, 8'h09, 8'h06); clear_all(0);
    m_xfer(3'd4, 8'h03, 8'h0A);
    chk("R10", status[6], 1, "overrun set");
    clear_all(1);
    chk("R3", status, 8'h01, "all flags cleared");

    // random master traffic
    for (int t = 0; t < 40; t++) begin
      logic [2:0] c = 3'($urandom_range(0, 7));
      logic [7:0] a = 8'($urandom), b = 8'($urandom);
      m_xfer(c, a, b);
      clear_all($urandom_range(0, 3) != 0);
    end
    clear_all(1);

    // collision
    char_bits = 0; tx_data = 8'hFF; tx_load = 1;
    step();
    tx_load = 0; ss_n = 0;
    step();
    chk("R11", status[5], 1, "collision flag");
    chk("R11", status[1], 0, "master stopped");
    chk("R12", status[0], 0, "select state in master");
    ss_n = 1;
    step();
    clear_all(1);
    chk("R11", status, 8'h01, "collision cleared");

    // slave mode
    is_master = 0;
    step();
    s_xfer(3'd5, 8'h16, 8'h0B, 99); clear_all(1);
    s_xfer(3'd0, 8'hC3, 8'h5A, 3);
    clear_all(1);
    s_xfer(3'd0, 8'h00, 8'h00, 0);
    chk("R9", status[7], 0, "no irq on release before first bit");
    clear_all(1);
    for (int t = 0; t < 30; t++) begin
      logic [2:0] c = 3'($urandom_range(0, 7));
      logic [7:0] a = 8'($urandom), b = 8'($urandom);
      s_xfer(c, a, b, ($urandom_range(0, 3) == 0) ? $urandom_range(1, blen(c)) : 99);
      clear_all($urandom_range(0, 3) != 0);
    end

    // disable forces reset value
    force_irq = 1; ss_n = 0;
    step();
    force_irq = 0;
    chk("R12", status[0], 0, "selected state");
    spi_en = 0;
    step();
    chk("R1", status, 8'h01, "disable forces reset value");
    ss_n = 1;
    step();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule